// File: doc/BRIEF.md
# In-Band Loopback Code Generator and Detector

This block inserts and recognises repeating loopback request patterns on a serial line bit stream. Two short patterns are programmable: one asks the far end to close a loopback ("activate") and one asks it to release it ("deactivate"). Each pattern has a 2-bit length field and an 8-bit value. One bit-rate enable pulse marks each bit period. All data movement happens only on cycles where that enable is high.

On the transmit side, a control bit replaces the outgoing data with an endless repetition of the selected pattern. This lasts until the bit is cleared. On the receive side, two independent correlators align to the incoming stream and follow it bit by bit. A correlator tolerates a sparse error rate, so framing bits and line errors do not break it. It raises its detect flag only after the pattern has persisted for a mode-dependent time: about 25 ms at the 2.048 Mbit/s rate and about 33.16 ms at the 1.544 Mbit/s rate. Every change of a detect flag produces a one-cycle interrupt pulse.

Top module: `ilb_codec`

## Requirements
- R1: After reset, `tx_data_out`, both detect flags and both interrupt pulses are 0.
- R2: A length field value f selects a pattern of 5+f bits (00=5, 01=6, 10=7, 11=8). The pattern is bits [5+f-1:0] of its code register, sent and matched most significant bit first. The common activate request is length 00 with code 00001.
- R3: When `send_act`=1, `send_deact`=0 and `send_seq`=0, every bit period outputs the next bit of the repeating activate pattern. The first bit after the selection begins is code bit [L-1].
- R4: When `send_deact`=1, `send_act`=0 and `send_seq`=0, the deactivate pattern is sent the same way.
- R5: In every other combination of the three send bits, `tx_data_out` is `tx_data_in` from the same bit period. The output is registered: it changes on the clock edge at which `bit_en` is sampled high.
- R6: A correlator locks when the last L received bits equal its pattern exactly, including the bit just received. It then expects the pattern to continue from its first bit.
- R7: After lock, the detect flag rises on the locked bit whose count since lock exceeds the threshold. The threshold is PERSIST_E1 when `mode_t1`=0 and PERSIST_T1 when `mode_t1`=1. By default these are 51200 and 51199 bit periods.
- R8: Locked bits are grouped into blocks of 128, starting at lock. One mismatching bit per block is tolerated. A second mismatch in the same block drops lock, clears the detect flag and restarts the persistence count.
- R9: Each interrupt output pulses high for exactly one clock in the cycle in which its detect flag changes, in either direction.
- R10: In cycles with `bit_en` low, the transmit output, the detect flags and all internal progress hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One pulse per line bit period |
| mode_t1 | input | 1 | 0: 2.048 Mbit/s timing, 1: 1.544 Mbit/s timing |
| tx_data_in | input | 1 | Outgoing data from the framer |
| send_act | input | 1 | Request activate pattern transmission |
| send_deact | input | 1 | Request deactivate pattern transmission |
| send_seq | input | 1 | Test sequence transmission in progress (blocks patterns) |
| act_len | input | 2 | Activate pattern length field |
| act_code | input | 8 | Activate pattern value |
| deact_len | input | 2 | Deactivate pattern length field |
| deact_code | input | 8 | Deactivate pattern value |
| rx_data_in | input | 1 | Received line data |
| tx_data_out | output | 1 | Transmit data after pattern insertion |
| act_det | output | 1 | Activate pattern detected |
| deact_det | output | 1 | Deactivate pattern detected |
| act_irq | output | 1 | Activate detect status change pulse |
| deact_irq | output | 1 | Deactivate detect status change pulse |

## Verification
The assertions assume that the send bits, lengths, codes and `mode_t1` change only between bit periods. They also assume that `bit_en` is a plain qualifier and not a clock, so flags can move only after a sampled enable. The stimulus changes its controls only at falling edges. It uses enable patterns that are continuous, that alternate, and that follow a pseudo-random sequence. The persistence thresholds are reduced to a few hundred bits, which keeps lock, detection, loss and relock within a short run while the counting rules stay unchanged.

// File: rtl/ilb_pkg.sv
package ilb_pkg;
    localparam int LEN_W   = 2;
    localparam int MIN_LEN = 5;
    localparam int CODE_W  = MIN_LEN + (1 << LEN_W) - 1;
    localparam int PH_W    = $clog2(CODE_W);

    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_ACT   = 2'd1,
        SEL_DEACT = 2'd2
    } tx_sel_e;

    function automatic logic [3:0] pat_bits(input logic [LEN_W-1:0] f);
        return 4'(MIN_LEN) + 4'(f);
    endfunction

    function automatic logic [CODE_W-1:0] pat_mask(input logic [LEN_W-1:0] f);
        logic [CODE_W-1:0] m;
        for (int i = 0; i < CODE_W; i++) m[i] = (i < int'(pat_bits(f)));
        return m;
    endfunction
endpackage

// File: rtl/ilb_tx_gen.sv
module ilb_tx_gen
    import ilb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              data_in,
    input  logic              send_act,
    input  logic              send_deact,
    input  logic              send_seq,
    input  logic [LEN_W-1:0]  act_len,
    input  logic [CODE_W-1:0] act_code,
    input  logic [LEN_W-1:0]  deact_len,
    input  logic [CODE_W-1:0] deact_code,
    output logic              data_out
);
    typedef struct packed {
        tx_sel_e         sel;
        logic [PH_W-1:0] phase;
        logic            dout;
    } tx_state_t;

    tx_state_t st_d, st_q;
    tx_sel_e   sel;
    logic [LEN_W-1:0]  len;
    logic [CODE_W-1:0] code;
    logic [3:0]        nbits;
    logic [3:0]        p;

    always_comb begin
        st_d = st_q;
        sel  = SEL_PASS;
        p    = '0;
        if (send_act && !send_deact && !send_seq)      sel = SEL_ACT;
        else if (send_deact && !send_act && !send_seq) sel = SEL_DEACT;
        len   = (sel == SEL_ACT) ? act_len  : deact_len;
        code  = (sel == SEL_ACT) ? act_code : deact_code;
        nbits = pat_bits(len);
        if (bit_en) begin
            st_d.sel = sel;
            if (sel == SEL_PASS) begin
                st_d.dout  = data_in;
                st_d.phase = '0;
            end else begin
                p = (sel != st_q.sel) ? 4'd0 : 4'(st_q.phase);
                if (p >= nbits) p = 4'd0;
                st_d.dout  = code[3'(nbits - 4'd1 - p)];
                st_d.phase = (p + 4'd1 == nbits) ? '0 : PH_W'(p + 4'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sel: SEL_PASS, phase: '0, dout: 1'b0};
        else        st_q <= st_d;
    end

    assign data_out = st_q.dout;
endmodule

// File: rtl/ilb_rx_det.sv
module ilb_rx_det
    import ilb_pkg::*;
#(
    parameter int PERSIST_E1 = 51200,
    parameter int PERSIST_T1 = 51199,
    parameter int BLOCK_BITS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              mode_t1,
    input  logic [LEN_W-1:0]  len,
    input  logic [CODE_W-1:0] code,
    output logic              det,
    output logic              irq
);
    localparam int PMAX  = (PERSIST_E1 > PERSIST_T1) ? PERSIST_E1 : PERSIST_T1;
    localparam int TMR_W = $clog2(PMAX + 2);
    localparam int BLK_W = $clog2(BLOCK_BITS);
    localparam int FIL_W = $clog2(CODE_W + 1);

    typedef struct packed {
        logic [CODE_W-1:0] hist;
        logic [FIL_W-1:0]  fill;
        logic              locked;
        logic [PH_W-1:0]   phase;
        logic [BLK_W-1:0]  blk;
        logic              err_seen;
        logic [TMR_W-1:0]  timer;
        logic              det;
        logic              irq;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [3:0]       nbits;
    logic [3:0]       p;
    logic [TMR_W-1:0] thr;
    logic             mis;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        nbits    = pat_bits(len);
        thr      = mode_t1 ? TMR_W'(PERSIST_T1) : TMR_W'(PERSIST_E1);
        p        = '0;
        mis      = 1'b0;
        if (bit_en) begin
            st_d.hist = {st_q.hist[CODE_W-2:0], rx_bit};
            if (st_q.fill != FIL_W'(CODE_W)) st_d.fill = st_q.fill + 1'b1;
            if (!st_q.locked) begin
                if (4'(st_d.fill) >= nbits &&
                    ((st_d.hist ^ code) & pat_mask(len)) == '0) begin
                    st_d.locked   = 1'b1;
                    st_d.phase    = '0;
                    st_d.blk      = '0;
                    st_d.err_seen = 1'b0;
                    st_d.timer    = '0;
                end
            end else begin
                p = 4'(st_q.phase);
                if (p >= nbits) p = 4'd0;
                mis        = (rx_bit != code[3'(nbits - 4'd1 - p)]);
                st_d.phase = (p + 4'd1 == nbits) ? '0 : PH_W'(p + 4'd1);
                if (mis && st_q.err_seen) begin
                    st_d.locked = 1'b0;
                    st_d.timer  = '0;
                    st_d.det    = 1'b0;
                end else begin
                    if (st_q.blk == BLK_W'(BLOCK_BITS - 1)) begin
                        st_d.blk      = '0;
                        st_d.err_seen = 1'b0;
                    end else begin
                        st_d.blk      = st_q.blk + 1'b1;
                        st_d.err_seen = st_q.err_seen | mis;
                    end
                    if (st_q.timer <= thr) st_d.timer = st_q.timer + 1'b1;
                    if (st_d.timer > thr)  st_d.det   = 1'b1;
                end
            end
        end
        st_d.irq = (st_d.det != st_q.det);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det = st_q.det;
    assign irq = st_q.irq;
endmodule

// File: rtl/ilb_codec.sv
module ilb_codec
    import ilb_pkg::*;
#(
    parameter int PERSIST_E1 = 51200,
    parameter int PERSIST_T1 = 51199,
    parameter int BLOCK_BITS = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       mode_t1,
    input  logic       tx_data_in,
    input  logic       send_act,
    input  logic       send_deact,
    input  logic       send_seq,
    input  logic [1:0] act_len,
    input  logic [7:0] act_code,
    input  logic [1:0] deact_len,
    input  logic [7:0] deact_code,
    input  logic       rx_data_in,
    output logic       tx_data_out,
    output logic       act_det,
    output logic       deact_det,
    output logic       act_irq,
    output logic       deact_irq
);
    localparam int N_CODES = 2;

    logic [LEN_W-1:0]  len_arr  [N_CODES];
    logic [CODE_W-1:0] code_arr [N_CODES];
    logic [N_CODES-1:0] det_v, irq_v;

    assign len_arr[0]  = act_len;
    assign len_arr[1]  = deact_len;
    assign code_arr[0] = act_code;
    assign code_arr[1] = deact_code;

    ilb_tx_gen u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .data_in    (tx_data_in),
        .send_act   (send_act),
        .send_deact (send_deact),
        .send_seq   (send_seq),
        .act_len    (act_len),
        .act_code   (act_code),
        .deact_len  (deact_len),
        .deact_code (deact_code),
        .data_out   (tx_data_out)
    );

    for (genvar k = 0; k < N_CODES; k++) begin : g_det
        ilb_rx_det #(
            .PERSIST_E1 (PERSIST_E1),
            .PERSIST_T1 (PERSIST_T1),
            .BLOCK_BITS (BLOCK_BITS)
        ) u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .bit_en  (bit_en),
            .rx_bit  (rx_data_in),
            .mode_t1 (mode_t1),
            .len     (len_arr[k]),
            .code    (code_arr[k]),
            .det     (det_v[k]),
            .irq     (irq_v[k])
        );
    end

    assign act_det   = det_v[0];
    assign deact_det = det_v[1];
    assign act_irq   = irq_v[0];
    assign deact_irq = irq_v[1];
endmodule

// File: rtl/ilb_codec_chk.sv
module ilb_codec_chk #(
    parameter int PERSIST_E1 = 51200,
    parameter int PERSIST_T1 = 51199
) (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_data_in,
    input logic send_act,
    input logic send_deact,
    input logic send_seq,
    input logic tx_data_out,
    input logic act_det,
    input logic deact_det,
    input logic act_irq,
    input logic deact_irq
);
    localparam int MINP = (PERSIST_E1 < PERSIST_T1) ? PERSIST_E1 : PERSIST_T1;
    localparam int CW   = $clog2(MINP + 2);

    logic [CW-1:0] bits_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               bits_seen <= '0;
        else if (bit_en && bits_seen <= CW'(MINP)) bits_seen <= bits_seen + 1'b1;
    end

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && (send_seq || (send_act == send_deact))) |=> (tx_data_out == $past(tx_data_in))); // R5
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_data_out)); // R10
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(act_det)); // R10
    AST_DEACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(deact_det)); // R10
    AST_ACT_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_det) |-> act_irq); // R9
    AST_ACT_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(act_det) |-> !act_irq); // R9
    AST_DEACT_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(deact_det) |-> deact_irq); // R9
    AST_DEACT_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(deact_det) |-> !deact_irq); // R9
    AST_ACT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_det) |-> (bits_seen > CW'(MINP))); // R7
    AST_DEACT_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deact_det) |-> (bits_seen > CW'(MINP))); // R7
endmodule

bind ilb_codec ilb_codec_chk #(
    .PERSIST_E1 (PERSIST_E1),
    .PERSIST_T1 (PERSIST_T1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .tx_data_in  (tx_data_in),
    .send_act    (send_act),
    .send_deact  (send_deact),
    .send_seq    (send_seq),
    .tx_data_out (tx_data_out),
    .act_det     (act_det),
    .deact_det   (deact_det),
    .act_irq     (act_irq),
    .deact_irq   (deact_irq)
);

// File: tb/ilb_codec_bench.sv
`timescale 1ns/1ps
module ilb_codec_bench;
    localparam int PE1 = 300;
    localparam int PT1 = 200;

    logic clk = 0, rst_n = 0;
    logic bit_en = 0, mode_t1 = 0, tx_data_in = 0, rx_data_in = 0;
    logic send_act = 0, send_deact = 0, send_seq = 0;
    logic [1:0] act_len = 0, deact_len = 0;
    logic [7:0] act_code = 0, deact_code = 0;
    logic tx_data_out, act_det, deact_det, act_irq, deact_irq;

    always #10 clk = ~clk;

    ilb_codec #(.PERSIST_E1(PE1), .PERSIST_T1(PT1)) u_ilb_codec (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .mode_t1(mode_t1),
        .tx_data_in(tx_data_in), .send_act(send_act), .send_deact(send_deact),
        .send_seq(send_seq), .act_len(act_len), .act_code(act_code),
        .deact_len(deact_len), .deact_code(deact_code), .rx_data_in(rx_data_in),
        .tx_data_out(tx_data_out), .act_det(act_det), .deact_det(deact_det),
        .act_irq(act_irq), .deact_irq(deact_irq));

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";

    // behavioural reference
    int m_sel = 0, m_ph = 0, m_fill = 0;
    bit m_tx = 0;
    bit [7:0] m_hist = 0;
    int  m_lock[2], m_phd[2], m_blk[2], m_err[2], m_tmr[2];
    bit  m_det[2], m_irq[2];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_ph = 0; m_tx = 0; m_hist = 0; m_fill = 0;
            for (int k = 0; k < 2; k++) begin
                m_lock[k] = 0; m_phd[k] = 0; m_blk[k] = 0; m_err[k] = 0;
                m_tmr[k] = 0; m_det[k] = 0; m_irq[k] = 0;
            end
        end else if (bit_en) begin
            int sel, len, p, thr;
            bit [7:0] c;
            sel = (send_act && !send_deact && !send_seq) ? 1 :
                  (send_deact && !send_act && !send_seq) ? 2 : 0;
            if (sel == 0) begin
                m_tx = tx_data_in; m_ph = 0;
            end else begin
                len = 5 + ((sel == 1) ? act_len : deact_len);
                c   = (sel == 1) ? act_code : deact_code;
                p   = (sel != m_sel) ? 0 : m_ph;
                if (p >= len) p = 0;
                m_tx = c[len-1-p];
                m_ph = (p + 1) % len;
            end
            m_sel  = sel;
            m_hist = {m_hist[6:0], rx_data_in};
            if (m_fill < 8) m_fill++;
            thr = mode_t1 ? PT1 : PE1;
            for (int k = 0; k < 2; k++) begin
                bit old;
                old = m_det[k];
                len = 5 + ((k == 0) ? act_len : deact_len);
                c   = (k == 0) ? act_code : deact_code;
                if (!m_lock[k]) begin
                    if (m_fill >= len && (((m_hist ^ c) & 8'((1 << len) - 1)) == 0)) begin
                        m_lock[k] = 1; m_phd[k] = 0; m_blk[k] = 0; m_err[k] = 0; m_tmr[k] = 0;
                    end
                end else begin
                    bit mis;
                    p = (m_phd[k] >= len) ? 0 : m_phd[k];
                    mis = (rx_data_in != c[len-1-p]);
                    m_phd[k] = (p + 1) % len;
                    if (mis && m_err[k] != 0) begin
                        m_lock[k] = 0; m_tmr[k] = 0; m_det[k] = 0;
                    end else begin
                        if (m_blk[k] == 127) begin m_blk[k] = 0; m_err[k] = 0; end
                        else begin m_blk[k]++; if (mis) m_err[k] = 1; end
                        if (m_tmr[k] <= thr) m_tmr[k]++;
                        if (m_tmr[k] > thr) m_det[k] = 1;
                    end
                end
                m_irq[k] = (m_det[k] != old);
            end
        end else begin
            m_irq[0] = 0; m_irq[1] = 0;
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", rq, what, act, exp, cycles);
        end
    endtask

    // stimulus sources
    int en_mode = 0;
    bit [15:0] lf = 16'hACE1;
    int rx_src = 0;          // 0 random, 1 activate pattern, 2 deactivate pattern
    int pat_ph = 0;
    bit flip_next = 0;
    int bit_cnt = 0;

    task automatic drive();
        int len; bit [7:0] c; bit b;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        case (en_mode)
            0: bit_en = 1;
            1: bit_en = (cycles % 2) == 0;
            default: bit_en = lf[3];
        endcase
        tx_data_in = lf[7];
        if (bit_en) begin
            if (rx_src == 0) b = lf[11];
            else begin
                len = 5 + ((rx_src == 1) ? act_len : deact_len);
                c   = (rx_src == 1) ? act_code : deact_code;
                if (pat_ph >= len) pat_ph = 0;
                b = c[len-1-pat_ph];
                pat_ph = (pat_ph + 1) % len;
            end
            if (flip_next) begin b = ~b; flip_next = 0; end
            rx_data_in = b;
        end
    endtask

    task automatic run(input int n);
        repeat (n) begin
            @(negedge clk);
            cycles++;
            chk(tag, "tx_data_out", tx_data_out, m_tx);
            chk((tag == "R9") ? "R9" : "R7", "act_det", act_det, m_det[0]);
            chk((tag == "R9") ? "R9" : "R7", "deact_det", deact_det, m_det[1]);
            chk("R9", "act_irq", act_irq, m_irq[0]);
            chk("R9", "deact_irq", deact_irq, m_irq[1]);
            drive();
        end
    endtask

    initial begin : watchdog
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "tx_data_out", tx_data_out, 0);
        chk("R1", "act_det", act_det, 0);
        chk("R1", "deact_det", deact_det, 0);
        chk("R1", "act_irq", act_irq, 0);
        chk("R1", "deact_irq", deact_irq, 0);
        rst_n = 1;

        // R5 and R10: pass-through with irregular enable
        tag = "R5"; en_mode = 2; run(80);

        // R3: standard activate request, length 00 code 00001
        tag = "R3"; en_mode = 0;
        act_len = 2'b00; act_code = 8'b0000_0001; send_act = 1; run(40);
        send_seq = 1; run(20); send_seq = 0;           // R3: blocked by sequence send
        run(12);

        // R4: deactivate, 8 bits, alternate enable
        tag = "R4"; en_mode = 1;
        send_act = 0; send_deact = 1; deact_len = 2'b11; deact_code = 8'hA5; run(40);
        send_act = 1; run(10);                          // R5: both set -> pass
        // R2: 7-bit activate pattern
        tag = "R2"; send_deact = 0; act_len = 2'b10; act_code = 8'b0101_1001; run(30);
        send_act = 0;

        // R6 and R7: activate detection, 2.048 Mbit/s timing
        tag = "R6"; en_mode = 0; mode_t1 = 0;
        act_len = 2'b01; act_code = 8'b0011_0010; rx_src = 1; pat_ph = 0; run(20);
        tag = "R7"; run(330);
        chk("R7", "act_det after persistence", act_det, 1);
        chk("R7", "deact_det idle", deact_det, 0);

        // R8: single errors per block tolerated, double error drops lock
        tag = "R8"; flip_next = 1; run(200); flip_next = 1; run(150);
        chk("R8", "act_det with sparse errors", act_det, 1);
        flip_next = 1; run(3); flip_next = 1; run(3);
        chk("R8", "act_det after dense errors", act_det, 0);
        tag = "R9"; run(340);
        chk("R9", "act_det relock", act_det, 1);

        // R7 and R10: deactivate detection, 1.544 Mbit/s timing, gapped enable
        tag = "R7"; mode_t1 = 1; en_mode = 1; rx_src = 2; pat_ph = 0; run(480);
        chk("R7", "deact_det in T1 mode", deact_det, 1);
        chk("R8", "act_det lost on foreign pattern", act_det, 0);
        tag = "R10"; en_mode = 2; rx_src = 0; run(200);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule